// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block supplies the divide value for the feedback counter of a fractional-N synthesizer. On every feedback-cycle strobe, it returns one whole-number divisor. The divisor sequence averages to an integer part plus a fraction of 2^18. A fixed half step of that fraction is always added, so the long-run ratio is `int_part + (frac_part + 0.5) / 2^18`.

The dithering comes from a third-order cascade of three first-order accumulators. Each accumulator is 19 bits wide and its input is the fraction with a constant 1 appended as the lowest bit. The cascade pushes quantisation noise to high offsets instead of producing the periodic pattern of simple pulse swallowing.

An integer-only control bypasses the cascade. In that mode the divisor is exactly the integer part, which gives a coarser frequency grid and no dithering noise.

Configuration is taken only on a strobe. A change of setting never clears the accumulators, so retuning is phase-continuous in the modulator.

Top module: `fracn_ratio_mod`

## Requirements
- R1: While `rst_n` is low and after reset until the first strobe, `div_val` is 0 and `div_vld` is 0; all modulator state starts at zero.
- R2: `div_vld` is high in exactly the cycle after a cycle in which `step` was sampled high, and low otherwise.
- R3: Between strobes `div_val` holds its value; changes of `int_part`, `frac_part` or `int_only` in cycles without `step` have no effect on any output.
- R4: A strobe with `int_only` high yields `div_val` equal to `int_part` (zero-extended to 8 bits).
- R5: A strobe with `int_only` low yields `div_val - int_part` in the range -3 to +4.
- R6: Starting from reset, the sum of `div_val` over N consecutive fractional-mode strobes with constant inputs is within -1..+2 of N*int_part + floor(N*(2*frac_part+1)/2^19).
- R7: Each fractional strobe output is int_part + c1[n] + (c2[n]-c2[n-1]) + (c3[n]-2*c3[n-1]+c3[n-2]). Here ck are the carries of three cascaded modulo-2^19 accumulators. The first accumulator adds 2*frac_part+1, and each later stage adds the new residue of the stage before it.
- R8: A change of `int_part` or `frac_part` taken at a strobe does not clear the accumulators or the carry history; the sequence continues from the existing state.
- R9: Strobes in integer-only mode freeze the accumulators and carry history, so fractional mode resumes where it left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-cycle strobe per feedback-divider cycle |
| int_only | input | 1 | 1: bypass the modulator, divide by the integer part |
| int_part | input | 7 | Integer part of the ratio |
| frac_part | input | 18 | Fractional part, in units of 2^-18 |
| div_val | output | 8 | Divide value for the coming feedback cycle |
| div_vld | output | 1 | High for one cycle when `div_val` is new |

## Verification
The range property assumes that `int_part` is at least 3, so that the lowest corrected value cannot wrap below zero in the 8-bit output. Every stimulus uses integer parts from 17 to 127. `step` is treated as an arbitrary single-cycle pulse with no minimum spacing. The stimulus mixes back-to-back strobes, strobes every third cycle, and input changes placed only in the cycles without a strobe.

// File: rtl/fracn_ratio_mod.sv
module fracn_ratio_mod #(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              int_only,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_part,
  output logic [INT_W:0]    div_val,
  output logic              div_vld
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] acc1, acc2, acc3;
  logic             c2_d1, c3_d1, c3_d2;

  logic [ACC_W-1:0] x_in;
  logic [ACC_W:0]   sum1, sum2, sum3;
  logic             c1, c2, c3;
  logic signed [3:0] corr;
  logic [INT_W:0]   div_next;

  assign x_in = {frac_part, 1'b1};
  assign sum1 = {1'b0, acc1} + {1'b0, x_in};
  assign sum2 = {1'b0, acc2} + {1'b0, sum1[ACC_W-1:0]};
  assign sum3 = {1'b0, acc3} + {1'b0, sum2[ACC_W-1:0]};
  assign c1   = sum1[ACC_W];
  assign c2   = sum2[ACC_W];
  assign c3   = sum3[ACC_W];

  assign corr = $signed({3'b000, c1}) + $signed({3'b000, c2}) + $signed({3'b000, c3})
              + $signed({3'b000, c3_d2}) - $signed({3'b000, c2_d1})
              - $signed({2'b00, c3_d1, 1'b0});

  assign div_next = {1'b0, int_part} + {{(INT_W-3){corr[3]}}, corr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1    <= '0;
      acc2    <= '0;
      acc3    <= '0;
      c2_d1   <= 1'b0;
      c3_d1   <= 1'b0;
      c3_d2   <= 1'b0;
      div_val <= '0;
      div_vld <= 1'b0;
    end else begin
      div_vld <= step;
      if (step) begin
        if (int_only) begin
          div_val <= {1'b0, int_part};
        end else begin
          acc1    <= sum1[ACC_W-1:0];
          acc2    <= sum2[ACC_W-1:0];
          acc3    <= sum3[ACC_W-1:0];
          c2_d1   <= c2;
          c3_d1   <= c3;
          c3_d2   <= c3_d1;
          div_val <= div_next;
        end
      end
    end
  end
endmodule

// File: rtl/fracn_ratio_mod_chk.sv
module fracn_ratio_mod_chk #(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              int_only,
  input logic [INT_W-1:0]  int_part,
  input logic [FRAC_W-1:0] frac_part,
  input logic [INT_W:0]    div_val,
  input logic              div_vld
);
  // R2
  vld_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> div_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !div_vld);

  // R3
  hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(div_val));

  // R4
  int_only_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && int_only) |=> (int'(div_val) == int'($past(int_part))));

  // R5
  corr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !int_only) |=>
      ((int'(div_val) - int'($past(int_part)) >= -3) &&
       (int'(div_val) - int'($past(int_part)) <= 4)));
endmodule

bind fracn_ratio_mod fracn_ratio_mod_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .int_only(int_only),
  .int_part(int_part), .frac_part(frac_part),
  .div_val(div_val), .div_vld(div_vld)
);

// File: tb/fracn_ratio_mod_test.sv
module fracn_ratio_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam longint MOD = 64'd1 << 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        int_only = 1'b0;
  logic [6:0]  int_part = '0;
  logic [17:0] frac_part = '0;
  logic [7:0]  div_val;
  logic        div_vld;

  int checks = 0;
  int errors = 0;

  longint m1, m2, m3;
  int p_c2, p_c3, pp_c3;
  int exp_val;
  bit exp_vld;
  longint win_sum;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_ratio_mod uut (
    .clk(clk), .rst_n(rst_n), .step(step), .int_only(int_only),
    .int_part(int_part), .frac_part(frac_part),
    .div_val(div_val), .div_vld(div_vld)
  );

  task automatic model_reset();
    m1 = 0; m2 = 0; m3 = 0;
    p_c2 = 0; p_c3 = 0; pp_c3 = 0;
    exp_val = 0; exp_vld = 0;
  endtask

  task automatic model_step(input int mi, input int fr, input bit io);
    int k1, k2, k3;
    if (io) begin
      exp_val = mi;
    end else begin
      m1 = m1 + 2*fr + 1;
      k1 = (m1 >= MOD) ? 1 : 0;
      if (k1 == 1) m1 = m1 - MOD;
      m2 = m2 + m1;
      k2 = (m2 >= MOD) ? 1 : 0;
      if (k2 == 1) m2 = m2 - MOD;
      m3 = m3 + m2;
      k3 = (m3 >= MOD) ? 1 : 0;
      if (k3 == 1) m3 = m3 - MOD;
      exp_val = mi + k1 + (k2 - p_c2) + (k3 - 2*p_c3 + pp_c3);
      p_c2 = k2;
      pp_c3 = p_c3;
      p_c3 = k3;
    end
  endtask

  task automatic check(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tick(input bit st, input int mi, input int fr, input bit io);
    @(negedge clk);
    step = st; int_part = mi[6:0]; frac_part = fr[17:0]; int_only = io;
    @(posedge clk);
    exp_vld = st;
    if (st) model_step(mi, fr, io);
    #1;
    check(div_vld === exp_vld, "R2 div_vld", int'(div_vld), int'(exp_vld));
    if (st && io)
      check(int'(div_val) == exp_val, "R4 int-only value", int'(div_val), exp_val);
    else if (st)
      check(int'(div_val) == exp_val, "R7 cascade value", int'(div_val), exp_val);
    else
      check(int'(div_val) == exp_val, "R3 hold between steps", int'(div_val), exp_val);
    if (st && !io)
      check((int'(div_val) - mi >= -3) && (int'(div_val) - mi <= 4),
            "R5 correction range", int'(div_val) - mi, 0);
    if (st) win_sum += div_val;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; step = 0;
    repeat (3) @(negedge clk);
    model_reset();
    check(div_val === 8'd0, "R1 reset value", int'(div_val), 0);
    check(div_vld === 1'b0, "R1 reset valid", int'(div_vld), 0);
    rst_n = 1;
  endtask

  task automatic window(input int mi, input int fr, input int n);
    longint base, diff;
    do_reset();
    win_sum = 0;
    for (int i = 0; i < n; i++) tick(1, mi, fr, 0);
    base = longint'(n) * mi + (longint'(n) * (2*fr + 1)) / MOD;
    diff = win_sum - base;
    check(diff >= -1 && diff <= 2, "R6 window average", int'(diff), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    win_sum = 0;
    repeat (2) @(negedge clk);
    // R1: outputs idle after reset and before any strobe
    do_reset();
    tick(0, 40, 5, 0);
    check(div_val === 8'd0, "R1 idle before first step", int'(div_val), 0);

    // R6: zero fraction still dithers by the half-LSB offset
    window(40, 0, 32768);
    // R6, R5: all-ones fraction near the carry limit
    window(17, 18'h3FFFF, 32768);
    // R6: top integer part with a mid fraction
    window(127, 18'h15555, 16384);

    // R8, R3: retune mid-run, strobe every third cycle, inputs wiggle between strobes
    do_reset();
    for (int i = 0; i < 600; i++) tick(1, 60, 18'h0A3D7, 0);
    for (int i = 0; i < 1500; i++) begin
      tick(1, 100, 18'h2AAAA, 0);
      tick(0, 33, 18'h11111, 1);
      tick(0, 90, 18'h3F00F, 0);
    end

    // R9, R4: integer-only strobes interleaved, state must be frozen across them
    for (int i = 0; i < 2000; i++) begin
      tick(1, 75, 18'h1234A, (i % 5) == 2);
      if (i % 7 == 0) tick(0, 20, 0, 1);
    end
    for (int i = 0; i < 300; i++) tick(1, 50, 18'h00F0F, 1);
    for (int i = 0; i < 300; i++) tick(1, 50, 18'h00F0F, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule